// File: doc/BRIEF.md
# MSI Write-Back Snooping Coherence Controller

Each private cache in this block sits behind a coherence controller that keeps one of three states per line: Modified, Shared or Invalid. Processor loads and stores hit locally where the state allows. Otherwise the controller requests a shared bus and broadcasts a read-for-sharing (GETS) or a read-for-ownership (GETX). While it waits it keeps watching the requests of the other caches. A cache holding a line in Modified owns that line. It raises a shared owner signal, puts its copy on the bus and downgrades. The memory model answers a request only when no cache claims ownership.

The top level holds one controller per core, a round-robin bus arbiter and a small word-addressed memory model. The bus carries exactly one transaction per cycle. That transaction is decided, snooped and completed in the same cycle, so every controller sees the transactions in a single common order. Dirty victims are written back in a separate transaction before the miss for the new line goes out.

Top module: `msi_snoop_system`

## Requirements
- R1: After reset, all lines are Invalid and every `cpu_ready` is high. The memory word at address a holds (17·a+3) mod 2^DATA_W. A load to an Invalid line issues one GETS (`bus_cmd`=0) and fills the line as Shared with the bus data. `cpu_done` pulses two cycles after acceptance, with `cpu_rdata` holding the value.
- R2: A load that hits a Shared or Modified line completes one cycle after acceptance and produces no bus transaction.
- R3: A store to a line that is Invalid or Shared issues one GETX (`bus_cmd`=1) and leaves the line Modified. Every other cache holding the line goes Invalid in that same bus cycle.
- R4: A store that hits a Modified line completes one cycle after acceptance, locally, with no bus transaction.
- R5: When another cache sends GETS for a line this cache holds Modified, this cache asserts `bus_owner`, drives its data onto `bus_data` and drops to Shared. Memory stores that data.
- R6: When another cache sends GETX, a Modified holder supplies its data with `bus_owner` set and goes Invalid. A Shared holder goes Invalid silently.
- R7: Replacing a Modified line first issues a writeback (`bus_cmd`=2) carrying the victim's address and data, which memory stores. The miss transaction follows, so that access completes three cycles after acceptance. Shared lines are replaced without any bus transaction.
- R8: Memory drives `bus_data` for GETS and GETX only while `bus_owner` is low. `bus_owner` is never high during a writeback.
- R9: The arbiter grants one requester per cycle. Priority rotates to the index after the last granted one. `bus_src` names the granted cache.
- R10: At most one cache asserts ownership in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | NCACHE | Per-core access request |
| cpu_store | input | NCACHE | Per-core: 1 store, 0 load |
| cpu_addr | input | NCACHE*ADDR_W | Per-core word address, core c at bits c*ADDR_W |
| cpu_wdata | input | NCACHE*DATA_W | Per-core store data |
| cpu_ready | output | NCACHE | Core may hand over an access this cycle |
| cpu_done | output | NCACHE | One-cycle completion pulse |
| cpu_rdata | output | NCACHE*DATA_W | Load result, valid with cpu_done |
| bus_valid | output | 1 | A transaction occupies the bus this cycle |
| bus_cmd | output | 2 | 0 GETS, 1 GETX, 2 writeback |
| bus_src | output | SRC_W | Index of the granted cache |
| bus_addr | output | ADDR_W | Transaction address |
| bus_owner | output | 1 | A cache holds the line Modified and supplies it |
| bus_data | output | DATA_W | Data driven by the owner, memory or writeback source |

## Verification
A local hit pulses `cpu_done` one cycle after the accepting edge. A miss needs one more cycle to take the bus, and a dirty replacement adds one more again. A second core that loses arbitration finishes one cycle after the winner. The driver counts negative edges from acceptance to the completion pulse and compares the count with these figures. Every bus transaction is taken at the negative edge of the cycle it occupies and compared in order against a queue of expected source, command, address and owner values. A stray transaction therefore fails at once, and a missing one fails at the next quiet checkpoint. Load data is checked against a coherent shadow copy of memory kept by the bench.

// File: rtl/msi_pkg.sv
package msi_pkg;
    typedef enum logic [1:0] {
        CMD_GETS = 2'd0,
        CMD_GETX = 2'd1,
        CMD_WB   = 2'd2
    } bus_cmd_e;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_M = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WB   = 2'd1,
        PH_MISS = 2'd2
    } ctrl_phase_e;
endpackage

// File: rtl/msi_cache_ctrl.sv
module msi_cache_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_store,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              req,
    output logic [1:0]        req_cmd,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    input  logic              bus_valid,
    input  logic              bus_mine,
    input  logic [1:0]        bus_cmd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              snoop_owner,
    output logic [DATA_W-1:0] snoop_data
);
    localparam int NLINES = 1 << IDX_W;
    localparam int TAG_W  = ADDR_W - IDX_W;

    typedef struct packed {
        ctrl_phase_e                     ph;
        logic                            store;
        logic [ADDR_W-1:0]               addr;
        logic [DATA_W-1:0]               wdata;
        logic                            done;
        logic [DATA_W-1:0]               rdata;
        logic [NLINES-1:0][1:0]          st;
        logic [NLINES-1:0][TAG_W-1:0]    tag;
        logic [NLINES-1:0][DATA_W-1:0]   dat;
    } ctrl_t;

    ctrl_t c_q, c_d;

    logic [IDX_W-1:0] s_idx, o_idx, n_idx;
    logic [TAG_W-1:0] s_tag, o_tag, n_tag;
    logic             s_active, s_hit, n_hit, blocked;

    always_comb begin
        // snoop side: another cache's GETS/GETX this cycle
        s_idx    = bus_addr[IDX_W-1:0];
        s_tag    = bus_addr[ADDR_W-1:IDX_W];
        s_active = bus_valid && !bus_mine && (bus_cmd != CMD_WB);
        s_hit    = s_active && (c_q.st[s_idx] != ST_I) && (c_q.tag[s_idx] == s_tag);

        o_idx = c_q.addr[IDX_W-1:0];
        o_tag = c_q.addr[ADDR_W-1:IDX_W];
        n_idx = cpu_addr[IDX_W-1:0];
        n_tag = cpu_addr[ADDR_W-1:IDX_W];
        n_hit = (c_q.st[n_idx] != ST_I) && (c_q.tag[n_idx] == n_tag);

        // a snoop on the same index this cycle holds off a new access
        blocked   = s_active && (s_idx == n_idx);
        cpu_ready = (c_q.ph == PH_IDLE) && !blocked;

        snoop_owner = s_hit && (c_q.st[s_idx] == ST_M);
        snoop_data  = snoop_owner ? c_q.dat[s_idx] : '0;

        req      = (c_q.ph == PH_MISS) || ((c_q.ph == PH_WB) && (c_q.st[o_idx] == ST_M));
        req_cmd  = (c_q.ph == PH_WB) ? CMD_WB : (c_q.store ? CMD_GETX : CMD_GETS);
        req_addr = (c_q.ph == PH_WB) ? {c_q.tag[o_idx], o_idx} : c_q.addr;
        req_data = c_q.dat[o_idx];

        c_d      = c_q;
        c_d.done = 1'b0;

        if (s_hit) begin
            if (bus_cmd == CMD_GETX)
                c_d.st[s_idx] = ST_I;
            else if (c_q.st[s_idx] == ST_M)
                c_d.st[s_idx] = ST_S;
        end

        unique case (c_q.ph)
            PH_IDLE: begin
                if (cpu_valid && cpu_ready) begin
                    c_d.store = cpu_store;
                    c_d.addr  = cpu_addr;
                    c_d.wdata = cpu_wdata;
                    if (n_hit && (!cpu_store || (c_q.st[n_idx] == ST_M))) begin
                        c_d.done  = 1'b1;
                        c_d.rdata = c_q.dat[n_idx];
                        if (cpu_store) begin
                            c_d.dat[n_idx] = cpu_wdata;
                            c_d.rdata      = cpu_wdata;
                        end
                    end else if (c_q.st[n_idx] == ST_M) begin
                        c_d.ph = PH_WB;
                    end else begin
                        c_d.ph = PH_MISS;
                    end
                end
            end
            PH_WB: begin
                if (bus_mine) begin
                    c_d.st[o_idx] = ST_I;
                    c_d.ph        = PH_MISS;
                end else if (c_q.st[o_idx] != ST_M) begin
                    // victim was taken away by a snoop: nothing left to write
                    c_d.ph = PH_MISS;
                end
            end
            PH_MISS: begin
                if (bus_mine) begin
                    c_d.tag[o_idx] = o_tag;
                    c_d.st[o_idx]  = c_q.store ? ST_M : ST_S;
                    c_d.dat[o_idx] = c_q.store ? c_q.wdata : bus_data;
                    c_d.rdata      = c_q.store ? c_q.wdata : bus_data;
                    c_d.done       = 1'b1;
                    c_d.ph         = PH_IDLE;
                end
            end
            default: c_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cpu_done  = c_q.done;
    assign cpu_rdata = c_q.rdata;
endmodule

// File: rtl/msi_rr_arbiter.sv
module msi_rr_arbiter #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             found;

    always_comb begin
        grant = '0;
        found = 1'b0;
        ptr_d = ptr_q;
        for (int i = 0; i < N; i++) begin
            if (!found && req[(int'(ptr_q) + i) % N]) begin
                found                         = 1'b1;
                grant[(int'(ptr_q) + i) % N]  = 1'b1;
                ptr_d = PTR_W'((int'(ptr_q) + i + 1) % N);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end
endmodule

// File: rtl/msi_memory.sv
module msi_memory
    import msi_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [1:0]        bus_cmd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_owner,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        rdata = mem_q[bus_addr];
        mem_d = mem_q;
        // writeback, or owner's data on a GETS: memory becomes owner again
        if (bus_valid && ((bus_cmd == CMD_WB) || ((bus_cmd == CMD_GETS) && bus_owner)))
            mem_d[bus_addr] = bus_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= DATA_W'(i * 17 + 3);
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/msi_snoop_system.sv
module msi_snoop_system
    import msi_pkg::*;
#(
    parameter int NCACHE = 2,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 1,
    localparam int SRC_W = (NCACHE > 1) ? $clog2(NCACHE) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCACHE-1:0]        cpu_valid,
    input  logic [NCACHE-1:0]        cpu_store,
    input  logic [NCACHE*ADDR_W-1:0] cpu_addr,
    input  logic [NCACHE*DATA_W-1:0] cpu_wdata,
    output logic [NCACHE-1:0]        cpu_ready,
    output logic [NCACHE-1:0]        cpu_done,
    output logic [NCACHE*DATA_W-1:0] cpu_rdata,
    output logic                     bus_valid,
    output logic [1:0]               bus_cmd,
    output logic [SRC_W-1:0]         bus_src,
    output logic [ADDR_W-1:0]        bus_addr,
    output logic                     bus_owner,
    output logic [DATA_W-1:0]        bus_data
);
    logic [NCACHE-1:0] req_vec, grant_vec, owner_vec;
    logic [1:0]        req_cmd   [NCACHE];
    logic [ADDR_W-1:0] req_addr  [NCACHE];
    logic [DATA_W-1:0] req_data  [NCACHE];
    logic [DATA_W-1:0] snp_data  [NCACHE];
    logic [DATA_W-1:0] wb_data, owner_data, mem_rdata;

    msi_rr_arbiter #(.N(NCACHE)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_vec),
        .grant (grant_vec)
    );

    for (genvar g = 0; g < NCACHE; g++) begin : g_cache
        msi_cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
            .clk         (clk),
            .rst_n       (rst_n),
            .cpu_valid   (cpu_valid[g]),
            .cpu_store   (cpu_store[g]),
            .cpu_addr    (cpu_addr[g*ADDR_W +: ADDR_W]),
            .cpu_wdata   (cpu_wdata[g*DATA_W +: DATA_W]),
            .cpu_ready   (cpu_ready[g]),
            .cpu_done    (cpu_done[g]),
            .cpu_rdata   (cpu_rdata[g*DATA_W +: DATA_W]),
            .req         (req_vec[g]),
            .req_cmd     (req_cmd[g]),
            .req_addr    (req_addr[g]),
            .req_data    (req_data[g]),
            .bus_valid   (bus_valid),
            .bus_mine    (grant_vec[g]),
            .bus_cmd     (bus_cmd),
            .bus_addr    (bus_addr),
            .bus_data    (bus_data),
            .snoop_owner (owner_vec[g]),
            .snoop_data  (snp_data[g])
        );
    end

    // transaction selection from the granted requester
    always_comb begin
        bus_cmd  = '0;
        bus_addr = '0;
        bus_src  = '0;
        wb_data  = '0;
        for (int i = 0; i < NCACHE; i++) begin
            if (grant_vec[i]) begin
                bus_cmd  = req_cmd[i];
                bus_addr = req_addr[i];
                bus_src  = SRC_W'(i);
                wb_data  = req_data[i];
            end
        end
        bus_valid = |grant_vec;
    end

    // data source: writer, owning cache, else memory
    always_comb begin
        owner_data = '0;
        for (int i = 0; i < NCACHE; i++)
            owner_data = owner_data | snp_data[i];
        bus_owner = |owner_vec;
        if (bus_cmd == CMD_WB)  bus_data = wb_data;
        else if (bus_owner)     bus_data = owner_data;
        else                    bus_data = mem_rdata;
    end

    msi_memory #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_cmd   (bus_cmd),
        .bus_addr  (bus_addr),
        .bus_owner (bus_owner),
        .bus_data  (bus_data),
        .rdata     (mem_rdata)
    );
endmodule

// File: rtl/msi_snoop_checker.sv
module msi_snoop_checker
    import msi_pkg::*;
#(
    parameter int N = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req_vec,
    input logic [N-1:0] grant_vec,
    input logic [N-1:0] owner_vec,
    input logic         bus_valid,
    input logic [1:0]   bus_cmd
);
    assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    assert_grant_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vec & ~req_vec) == '0);

    assert_grant_rotates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (&req_vec) && $past(&req_vec) && $past(bus_valid))
            |-> (grant_vec != $past(grant_vec)));

    assert_single_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(owner_vec));

    assert_no_owner_on_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (bus_cmd == CMD_WB)) |-> (owner_vec == '0));

    assert_owner_only_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|owner_vec) |-> (bus_valid && (bus_cmd != CMD_WB)));
endmodule

bind msi_snoop_system msi_snoop_checker #(.N(NCACHE)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vec   (req_vec),
    .grant_vec (grant_vec),
    .owner_vec (owner_vec),
    .bus_valid (bus_valid),
    .bus_cmd   (bus_cmd)
);

// File: tb/test_msi_snoop_system.sv
module test_msi_snoop_system;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cpu_valid = '0;
    logic [1:0]  cpu_store = '0;
    logic [7:0]  cpu_addr  = '0;
    logic [15:0] cpu_wdata = '0;
    logic [1:0]  cpu_ready, cpu_done;
    logic [15:0] cpu_rdata;
    logic        bus_valid, bus_owner;
    logic [1:0]  bus_cmd;
    logic [0:0]  bus_src;
    logic [3:0]  bus_addr;
    logic [7:0]  bus_data;

    msi_snoop_system i_msi_snoop_system (
        .clk, .rst_n, .cpu_valid, .cpu_store, .cpu_addr, .cpu_wdata,
        .cpu_ready, .cpu_done, .cpu_rdata, .bus_valid, .bus_cmd, .bus_src,
        .bus_addr, .bus_owner, .bus_data
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct { bit chk; logic [7:0] val; string rq; } rd_t;
    typedef struct { int cmd; int src; int addr; int own; string rq; } txn_t;

    rd_t  q0[$];
    rd_t  q1[$];
    txn_t bus_q[$];
    logic [7:0] golden [16];
    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // monitor: completions and bus transactions against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < 2; c++) begin
                if (cpu_done[c]) begin
                    rd_t e;
                    if ((c == 0 && q0.size() == 0) || (c == 1 && q1.size() == 0)) begin
                        check(1'b0, "R2 unexpected completion", c, -1);
                    end else begin
                        if (c == 0) e = q0.pop_front();
                        else        e = q1.pop_front();
                        if (e.chk) check(cpu_rdata[c*8 +: 8] == e.val, e.rq,
                                         int'(cpu_rdata[c*8 +: 8]), int'(e.val));
                    end
                end
            end
            if (bus_valid) begin
                txn_t t;
                if (bus_q.size() == 0) begin
                    check(1'b0, "R2/R4 unexpected bus transaction", int'(bus_cmd), -1);
                end else begin
                    t = bus_q.pop_front();
                    check(int'(bus_cmd) == t.cmd, {t.rq, " cmd"}, int'(bus_cmd), t.cmd);
                    check(int'(bus_src) == t.src, {t.rq, " src"}, int'(bus_src), t.src);
                    check(int'(bus_addr) == t.addr, {t.rq, " addr"}, int'(bus_addr), t.addr);
                    check(int'(bus_owner) == t.own, {t.rq, " owner"}, int'(bus_owner), t.own);
                end
            end
        end
    end

    task automatic exp_bus(input int cmd, input int src, input int addr, input int own, input string rq);
        txn_t t;
        t.cmd = cmd; t.src = src; t.addr = addr; t.own = own; t.rq = rq;
        bus_q.push_back(t);
    endtask

    // driver: push expectation, present access, measure latency
    task automatic op(input int c, input bit st, input int a, input logic [7:0] wd,
                      input int lat, input string rq);
        rd_t e;
        int  n;
        e.chk = !st; e.val = golden[a]; e.rq = rq;
        if (c == 0) q0.push_back(e); else q1.push_back(e);
        if (st) golden[a] = wd;
        @(negedge clk);
        cpu_valid[c]          = 1'b1;
        cpu_store[c]          = st;
        cpu_addr[c*4 +: 4]    = 4'(a);
        cpu_wdata[c*8 +: 8]   = wd;
        while (!cpu_ready[c]) @(negedge clk);
        @(negedge clk);
        cpu_valid[c] = 1'b0;
        n = 1;
        while (!cpu_done[c]) begin
            @(negedge clk);
            n++;
        end
        if (lat > 0) check(n == lat, {rq, " latency"}, n, lat);
    endtask

    task automatic settle(input string rq);
        repeat (3) @(negedge clk);
        check(bus_q.size() == 0 && q0.size() == 0 && q1.size() == 0, rq,
              bus_q.size() + q0.size() + q1.size(), 0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) golden[i] = 8'(i * 17 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(cpu_ready == 2'b11, "R1 reset ready", int'(cpu_ready), 3);
        check(cpu_done == 2'b00, "R1 reset done", int'(cpu_done), 0);
        check(bus_valid == 1'b0, "R1 reset bus idle", int'(bus_valid), 0);

        exp_bus(0, 0, 4, 0, "R1 R8 load miss GETS");
        op(0, 0, 4, 8'h00, 2, "R1 load miss");
        op(0, 0, 4, 8'h00, 1, "R2 shared load hit");
        settle("R2 no bus on hit");

        exp_bus(0, 1, 4, 0, "R1 second sharer");
        op(1, 0, 4, 8'h00, 2, "R1 load miss core1");
        exp_bus(1, 0, 4, 0, "R3 upgrade GETX");
        op(0, 1, 4, 8'hA5, 2, "R3 store from shared");
        // R3 R5 R10: core1 was invalidated, core0 is sole owner
        exp_bus(0, 1, 4, 1, "R5 owner supplies on GETS");
        op(1, 0, 4, 8'h00, 2, "R5 data from owner");
        op(0, 0, 4, 8'h00, 1, "R5 owner kept shared copy");
        settle("R5 checkpoint");

        exp_bus(1, 0, 4, 0, "R6 R8 GETX served by memory");
        op(0, 1, 4, 8'h5A, 2, "R3 store shared again");
        op(0, 1, 4, 8'h66, 1, "R4 store hit modified");
        settle("R4 no bus on modified store");

        exp_bus(1, 1, 4, 1, "R6 modified supplies on GETX");
        op(1, 1, 4, 8'h77, 2, "R6 store steals line");
        exp_bus(0, 0, 4, 1, "R6 previous owner invalid");
        op(0, 0, 4, 8'h00, 2, "R6 reload after invalidate");

        exp_bus(0, 1, 6, 0, "R7 shared victim silent");
        op(1, 0, 6, 8'h00, 2, "R7 replace shared line");
        exp_bus(1, 0, 6, 0, "R3 GETX invalidates sharer");
        op(0, 1, 6, 8'h11, 2, "R3 store miss");
        exp_bus(2, 0, 6, 0, "R7 R8 writeback of victim");
        exp_bus(0, 0, 4, 0, "R7 R5 miss after writeback");
        op(0, 0, 4, 8'h00, 3, "R7 R5 memory updated by owner");
        exp_bus(0, 1, 6, 0, "R7 memory holds written back data");
        op(1, 0, 6, 8'h00, 2, "R7 writeback data");
        settle("R7 checkpoint");

        // R9: simultaneous misses, pointer at core0
        exp_bus(0, 0, 3, 0, "R9 first grant core0");
        exp_bus(0, 1, 5, 0, "R9 then core1");
        fork
            op(0, 0, 3, 8'h00, 2, "R9 winner core0");
            op(1, 0, 5, 8'h00, 3, "R9 loser core1");
        join
        exp_bus(0, 0, 11, 0, "R9 single core0");
        op(0, 0, 11, 8'h00, 2, "R9 move pointer");
        exp_bus(0, 1, 15, 0, "R9 rotated grant core1");
        exp_bus(0, 0, 13, 0, "R9 then core0");
        fork
            op(0, 0, 13, 8'h00, 3, "R9 loser core0");
            op(1, 0, 15, 8'h00, 2, "R9 winner core1");
        join
        settle("R9 checkpoint");

        finish_run();
    end
endmodule